// File: doc/BRIEF.md
# Serial Block Receive Buffer

This block sits between a bit-serial device link and the transfer logic of a controller. A start marker opens a block. Data bits arrive one per valid strobe and are packed into bytes, which are written in order into an internal buffer. While the bytes arrive, the block keeps a running additive checksum over them. Once the buffer holds a full block, a 16-bit checksum field follows on the same serial line. The received field is compared with the running sum.

A block that passes is made available for draining one byte at a time through a read port. A one-cycle interrupt pulse announces it. A block that fails raises an error flag and can never be read. Reads return zero until a new start marker arrives.

The controller is a five-state machine:
- **ST_IDLE** waits for a start marker.
- **ST_DATA** packs data bytes and writes them to the buffer.
- **ST_CSUM** shifts in the checksum field.
- **ST_READY** allows reads.
- **ST_ERROR** holds a failed verdict.

The transitions are:
- A start marker moves any state to ST_DATA. This is the restart transition.
- ST_DATA moves to ST_CSUM when the last data byte is complete (data-done).
- ST_CSUM moves to ST_READY when the checksum matches (verdict-pass).
- ST_CSUM moves to ST_ERROR when the checksum does not match (verdict-fail).
- ST_READY moves to ST_IDLE when the final byte is read (drained).

Top module: `srx_block_rx`

## Requirements
- R1: After reset, `ready`, `error`, `irq` and `rd_valid` are 0 and `rd_data` is 0.
- R2: Data bits are packed most-significant-bit first; the first accepted bit is bit 7 of a byte. Bytes are stored in arrival order and read back in that same order, starting with the first byte received.
- R3: After `BLOCK_BYTES` data bytes, the next 16 accepted bits form the received checksum, most-significant bit first. It is compared with the sum of all data bytes modulo 65536.
- R4: On a checksum match, `ready` is 1 and `irq` is 1 in the cycle after the edge that accepts the final checksum bit. `irq` is 1 for exactly that one cycle.
- R5: On a checksum mismatch, `error` becomes 1, `ready` stays 0 and `irq` stays 0. A read request then gives `rd_valid`=0 and `rd_data`=0.
- R6: While a block is still being received, a read request gives `rd_valid`=0 and `rd_data`=0 and does not advance the read position. After a pass, the first read still returns the first byte.
- R7: In the ready state, a read request gives `rd_valid`=1 and the next byte on `rd_data` one cycle later. After the last byte of the block is read, `ready` falls to 0.
- R8: A start marker clears `ready` and `error` and restarts the write position at the first byte. A read request in the same cycle as the marker is not served (`rd_valid`=0). A data bit strobed in the marker cycle is not accepted.
- R9: Data bits strobed while no block is being received (idle, ready or error) are ignored. In the ready state they do not change the bytes that are read out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| blk_start | input | 1 | One-cycle start-of-block marker |
| bit_vld | input | 1 | Serial data bit strobe |
| bit_dat | input | 1 | Serial data bit |
| rd_req | input | 1 | Request the next buffered byte |
| rd_data | output | 8 | Byte returned for a served read, otherwise 0 |
| rd_valid | output | 1 | High for one cycle when `rd_data` holds a served byte |
| ready | output | 1 | A checked block is available for reading |
| error | output | 1 | The last block failed its checksum |
| irq | output | 1 | One-cycle pulse when a block passes its check |

## Verification
Two functions can land in the same cycle: a start marker and a read request. The marker can also coincide with a strobed data bit. The bench provokes the first case by asserting `blk_start` and `rd_req` together while a verified block is partly drained. It expects no served read, and expects `ready` to fall on the following cycle. In the same marker cycle it strobes a 1 bit. It then sends a fresh block and checks that every byte read back is aligned exactly as sent, which can only hold if that extra bit was dropped.

// File: rtl/srx_pkg.sv
package srx_pkg;
    localparam int BYTE_W = 8;
    localparam int CSUM_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_CSUM,
        ST_READY,
        ST_ERROR
    } srx_state_e;
endpackage

// File: rtl/srx_shift_pack.sv
module srx_shift_pack #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         bit_in,
    output logic [W-1:0] word_nxt,
    output logic         done
);
    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]     shreg;
    logic [CNT_W-1:0] cnt;

    assign word_nxt = {shreg[W-2:0], bit_in};
    assign done     = en && (cnt == CNT_W'(W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (clr) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (en) begin
            shreg <= word_nxt;
            cnt   <= done ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/srx_sum_acc.sv
module srx_sum_acc #(
    parameter int IN_W  = 8,
    parameter int SUM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add,
    input  logic [IN_W-1:0]  val,
    output logic [SUM_W-1:0] sum
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sum <= '0;
        else if (clr)    sum <= '0;
        else if (add)    sum <= sum + SUM_W'(val);
    end
endmodule

// File: rtl/srx_block_mem.sv
module srx_block_mem #(
    parameter int DEPTH = 512,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/srx_block_rx.sv
module srx_block_rx
    import srx_pkg::*;
#(
    parameter int BLOCK_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_start,
    input  logic              bit_vld,
    input  logic              bit_dat,
    input  logic              rd_req,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              ready,
    output logic              error,
    output logic              irq
);
    localparam int PTR_W = (BLOCK_BYTES > 1) ? $clog2(BLOCK_BYTES) : 1;
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(BLOCK_BYTES - 1);

    srx_state_e state, state_nxt;

    logic [PTR_W-1:0]  wptr, rptr;
    logic [BYTE_W-1:0] byte_word, mem_q;
    logic [CSUM_W-1:0] csum_word, sum;
    logic              byte_en, byte_done, csum_en, csum_done;
    logic              rd_fire, csum_ok;

    assign byte_en = bit_vld && !blk_start && (state == ST_DATA);
    assign csum_en = bit_vld && !blk_start && (state == ST_CSUM);
    assign rd_fire = rd_req  && !blk_start && (state == ST_READY);
    assign csum_ok = (csum_word == sum);

    srx_shift_pack #(.W(BYTE_W)) u_byte_pack (
        .clk(clk), .rst_n(rst_n), .clr(blk_start), .en(byte_en),
        .bit_in(bit_dat), .word_nxt(byte_word), .done(byte_done)
    );

    srx_shift_pack #(.W(CSUM_W)) u_csum_pack (
        .clk(clk), .rst_n(rst_n), .clr(blk_start), .en(csum_en),
        .bit_in(bit_dat), .word_nxt(csum_word), .done(csum_done)
    );

    srx_sum_acc #(.IN_W(BYTE_W), .SUM_W(CSUM_W)) u_sum (
        .clk(clk), .rst_n(rst_n), .clr(blk_start), .add(byte_done),
        .val(byte_word), .sum(sum)
    );

    srx_block_mem #(.DEPTH(BLOCK_BYTES), .DW(BYTE_W)) u_mem (
        .clk(clk), .we(byte_done), .waddr(wptr), .wdata(byte_word),
        .re(rd_fire), .raddr(rptr), .rdata(mem_q)
    );

    // next-state logic
    always_comb begin
        state_nxt = state;
        if (blk_start) begin
            state_nxt = ST_DATA;
        end else begin
            unique case (state)
                ST_IDLE:  state_nxt = ST_IDLE;
                ST_DATA:  if (byte_done && wptr == LAST_IDX) state_nxt = ST_CSUM;
                ST_CSUM:  if (csum_done) state_nxt = csum_ok ? ST_READY : ST_ERROR;
                ST_READY: if (rd_fire && rptr == LAST_IDX) state_nxt = ST_IDLE;
                ST_ERROR: state_nxt = ST_ERROR;
                default:  state_nxt = ST_IDLE;
            endcase
        end
    end

    // state register and pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            wptr  <= '0;
            rptr  <= '0;
        end else begin
            state <= state_nxt;
            if (blk_start) begin
                wptr <= '0;
                rptr <= '0;
            end else begin
                if (byte_done && wptr != LAST_IDX) wptr <= wptr + 1'b1;
                if (rd_fire) rptr <= (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq      <= 1'b0;
            rd_valid <= 1'b0;
        end else begin
            irq      <= (state == ST_CSUM) && csum_done && csum_ok && !blk_start;
            rd_valid <= rd_fire;
        end
    end

    assign ready   = (state == ST_READY);
    assign error   = (state == ST_ERROR);
    assign rd_data = rd_valid ? mem_q : '0;

    AST_IRQ_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ready); // R4
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R4
    AST_READ_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(state) == ST_READY); // R6
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && error)); // R5
    AST_ERROR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !blk_start) |=> error); // R5
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start |=> (!ready && !error && !rd_valid)); // R8
    AST_WPTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        wptr <= LAST_IDX); // R3
endmodule

// File: tb/srx_block_rx_tb.sv
module srx_block_rx_tb;
    localparam int BLK = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       blk_start = 1'b0, bit_vld = 1'b0, bit_dat = 1'b0, rd_req = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid, ready, error, irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_mem [BLK];

    always #10 clk = ~clk;

    srx_block_rx #(.BLOCK_BYTES(BLK)) u_dut (
        .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .bit_vld(bit_vld),
        .bit_dat(bit_dat), .rd_req(rd_req), .rd_data(rd_data),
        .rd_valid(rd_valid), .ready(ready), .error(error), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fill(input int kind);
        for (int i = 0; i < BLK; i++) begin
            case (kind)
                0:       exp_mem[i] = 8'((i * 17 + 3) & 255);
                1:       exp_mem[i] = 8'hFF;
                default: exp_mem[i] = 8'((i * 5) ^ 8'hA5);
            endcase
        end
    endtask

    function automatic logic [15:0] exp_sum();
        int s = 0;
        for (int i = 0; i < BLK; i++) s += exp_mem[i];
        return 16'(s % 65536);
    endfunction

    task automatic send_bit(input logic b);
        bit_vld = 1'b1; bit_dat = b;
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, input bit gaps);
        for (int k = 7; k >= 0; k--) begin
            send_bit(v[k]);
            if (gaps && k == 4) @(negedge clk);
        end
    endtask

    task automatic start();
        blk_start = 1'b1;
        @(negedge clk);
        blk_start = 1'b0;
    endtask

    task automatic send_data(input bit gaps);
        for (int i = 0; i < BLK; i++) send_byte(exp_mem[i], gaps && (i % 3 == 0));
    endtask

    task automatic send_csum_but_last(input logic [15:0] c);
        for (int k = 15; k >= 1; k--) send_bit(c[k]);
    endtask

    task automatic do_read(output logic v, output logic [7:0] d);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        v = rd_valid; d = rd_data;
    endtask

    task automatic drain_check(input int from, input string req);
        logic v; logic [7:0] d;
        for (int i = from; i < BLK; i++) begin
            do_read(v, d);
            if (!v || d != exp_mem[i]) check(1'b0, req, int'(d), int'(exp_mem[i]));
        end
        check(1'b1, req, 0, 0);
    endtask

    task automatic t_reset();
        check(ready == 0 && error == 0 && irq == 0 && rd_valid == 0 && rd_data == 0,
              "R1", {ready, error, irq, rd_valid}, 0);
    endtask

    task automatic t_good_block();
        logic v; logic [7:0] d; logic [15:0] c;
        fill(0); c = exp_sum();
        start();
        send_data(1'b1);
        send_csum_but_last(c);
        do_read(v, d);
        check(v == 0 && d == 0 && ready == 0, "R6", int'(d), 0);
        send_bit(c[0]);
        check(ready == 1 && irq == 1, "R4", {ready, irq}, 3);
        @(negedge clk);
        check(irq == 0, "R4", irq, 0);
        do_read(v, d);
        check(v == 1 && d == exp_mem[0], "R6", int'(d), int'(exp_mem[0]));
        check(v == 1 && d == exp_mem[0], "R2", int'(d), int'(exp_mem[0]));
        drain_check(1, "R7");
        check(ready == 0, "R7", ready, 0);
    endtask

    task automatic t_bad_block();
        logic v; logic [7:0] d; logic [15:0] c;
        fill(2); c = exp_sum() + 16'd1;
        start();
        send_data(1'b0);
        for (int k = 15; k >= 0; k--) send_bit(c[k]);
        check(error == 1 && ready == 0 && irq == 0, "R5", {error, ready, irq}, 4);
        do_read(v, d);
        check(v == 0 && d == 0, "R5", int'(d), 0);
        start();
        check(error == 0, "R8", error, 0);
    endtask

    task automatic t_wrap_and_restart();
        logic [15:0] c;
        fill(0);
        start();
        for (int i = 0; i < 5; i++) send_byte(8'h3C, 1'b0);
        fill(1); c = exp_sum();
        check(c == 16'd10964, "R3", c, 10964);
        start();
        send_data(1'b0);
        for (int k = 15; k >= 0; k--) send_bit(c[k]);
        check(ready == 1, "R3", ready, 1);
        drain_check(0, "R8");
    endtask

    task automatic t_collision();
        logic v; logic [7:0] d; logic [15:0] c;
        fill(2); c = exp_sum();
        start();
        send_data(1'b0);
        for (int k = 15; k >= 0; k--) send_bit(c[k]);
        check(ready == 1, "R4", ready, 1);
        for (int k = 0; k < 20; k++) send_bit(1'b1);
        check(ready == 1, "R9", ready, 1);
        do_read(v, d);
        check(v == 1 && d == exp_mem[0], "R9", int'(d), int'(exp_mem[0]));
        do_read(v, d);
        check(v == 1 && d == exp_mem[1], "R7", int'(d), int'(exp_mem[1]));
        fill(0); c = exp_sum();
        blk_start = 1'b1; rd_req = 1'b1; bit_vld = 1'b1; bit_dat = 1'b1;
        @(negedge clk);
        blk_start = 1'b0; rd_req = 1'b0; bit_vld = 1'b0;
        check(rd_valid == 0 && rd_data == 0 && ready == 0, "R8", {rd_valid, ready}, 0);
        send_data(1'b1);
        for (int k = 15; k >= 0; k--) send_bit(c[k]);
        check(ready == 1, "R8", ready, 1);
        drain_check(0, "R2");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_good_block();
        t_bad_block();
        t_wrap_and_restart();
        t_collision();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule